// File: doc/BRIEF.md
# Parallel Converter Read Sequencer

This block runs on the host side of a 12-bit sampling converter that has a parallel, three-state output bus. It drives three control lines toward the converter: an active-low select, an active-low read strobe and a byte-select line. It watches the converter's status line, which is low while a conversion is running. A read strobe issued with the byte-select line low also starts a new conversion. For that reason the sequencer orders its strobes so that every conversion it triggers is complete before its data is fetched. It also holds the byte-select line high for the whole upper-half fetch, so that this fetch never starts a conversion.

The host starts a transfer by pulsing a request and choosing either word access or byte access. Word access uses two strobes: one to trigger, then one that reads all twelve lines. Byte access uses three strobes: a trigger, a lower-byte read with byte-select low, and an upper-half read with byte-select high. During the upper-half read, result bits 11..8 arrive on the four lowest data lines and the next four lines must read zero. The assembled 12-bit word is presented together with a one-cycle done pulse. Two error flags are valid alongside done: one for a bad zero fill and one for a status line that failed to reach the awaited level in time. Strobe width, the idle gap between strobes and the status time limit are parameters.

Top module: `adc_byte_reader`

## Requirements
- R1: After reset the select and read lines are high (inactive), byte-select is low and done is low.
- R2: Each read strobe holds the read line low for exactly STROBE_CYC clock cycles, and the select line is low before the first strobe of a transfer.
- R3: The read line is low only while the select line is low, and the select line stays low from the first strobe of a transfer to the end of its last strobe.
- R4: The byte-select line does not change while the read line is low. It is low for the trigger strobe and for the lower or word read, and high for the whole upper-half read.
- R5: Between two strobes of one transfer the read line stays high for at least GAP_CYC cycles.
- R6: The data-read strobe (the second strobe) starts only after the status line has been seen low and then high again following the trigger strobe.
- R7: In word access (mode input 0) the result equals the 12 data lines sampled in the last cycle of the second strobe, line 11 being the MSB.
- R8: In byte access (mode input 1) exactly three strobes are issued. Result bits 7..0 come from data lines 7..0 of the second strobe. Result bits 11..8 come from data lines 3..0 of the third strobe.
- R9: In byte access, if data lines 7..4 are nonzero during the upper-half strobe, the protocol error flag is 1 together with done. Otherwise it is 0.
- R10: If the status line has not reached the awaited level within TIMEOUT_CYC cycles, the transfer is abandoned. Done is then pulsed with the timeout flag set, and the select line returns high.
- R11: Done is a single-cycle pulse. A request that arrives while a transfer is in progress is ignored, and no second transfer follows from it.
- R12: The trigger strobe is issued only while the status line is high (converter idle). While the status line stays low, no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start request, sampled while idle |
| mode_byte_i | input | 1 | 0 = word access, 1 = byte access; latched with the request |
| busy_i | input | 1 | Converter status, low while converting |
| data_i | input | 12 | Converter data lines |
| cs_n_o | output | 1 | Active-low converter select |
| rd_n_o | output | 1 | Active-low read strobe (also the conversion trigger) |
| hben_o | output | 1 | Byte-select: high fetches bits 11..8 on the low lines |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 12 | Assembled conversion result, valid with done |
| err_proto_o | output | 1 | Zero-fill violation seen in the upper-half fetch, valid with done |
| err_timeout_o | output | 1 | Status-line time limit expired, valid with done |

## Verification
A wrong sequencer state shows up at the pins within the same transfer. A phase register that lags or advances changes the strobe count, or gives the byte-select pattern across strobes 0/0/1 in the wrong place. A strobe or gap counter that is off by one changes the measured low and high runs of the read line by one cycle. Capture logic that latches on the wrong strobe or the wrong lines shows as a result that differs from the converter's held value at the very next done. A faulty wait or timer path shows either as a read issued before the status line has gone low and back high, or as a done that comes earlier or later than the time limit allows.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

   localparam int unsigned RES_W = 12;
   localparam int unsigned NIB_W = 4;
   localparam int unsigned LOB_W = 8;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ARM,
      S_STRB,
      S_GAP,
      S_WLO,
      S_WHI,
      S_DONE
   } seq_t;

   typedef enum logic [1:0] {
      PH_TRIG,
      PH_LOW,
      PH_HIGH,
      PH_END
   } phase_t;

endpackage

// File: rtl/adcrd_pace.sv
module adcrd_pace #(
   parameter int unsigned LIMIT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic hit
);

   initial begin
      assert (LIMIT >= 1) else $error("adcrd_pace: LIMIT must be at least 1");
   end

   generate
      if (LIMIT <= 1) begin : g_single
         assign hit = run;
      end else begin : g_count
         localparam int unsigned CW = $clog2(LIMIT);
         localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!run) begin
               cnt <= '0;
            end else if (cnt != LAST) begin
               cnt <= cnt + 1'b1;
            end
         end

         assign hit = run && (cnt == LAST);
      end
   endgenerate

endmodule

// File: rtl/adcrd_assemble.sv
module adcrd_assemble
   import adcrd_pkg::*;
#(
   parameter bit CHECK_FILL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             word_mode,
   input  logic             cap_low,
   input  logic             cap_high,
   input  logic [RES_W-1:0] data_i,
   output logic [RES_W-1:0] result_o,
   output logic             err_proto_o
);

   logic [RES_W-1:0] res_q;
   logic [NIB_W-1:0] fill_lines;

   assign fill_lines = data_i[LOB_W-1:NIB_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
      end else if (cap_low) begin
         if (word_mode) begin
            res_q <= data_i;
         end else begin
            res_q[LOB_W-1:0] <= data_i[LOB_W-1:0];
         end
      end else if (cap_high) begin
         res_q[RES_W-1:LOB_W] <= data_i[NIB_W-1:0];
      end
   end

   assign result_o = res_q;

   generate
      if (CHECK_FILL) begin : g_fill_check
         logic err_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               err_q <= 1'b0;
            end else if (start) begin
               err_q <= 1'b0;
            end else if (cap_high && (fill_lines != '0)) begin
               err_q <= 1'b1;
            end
         end
         assign err_proto_o = err_q;

         // R9: a nonzero fill during the upper fetch must be flagged next cycle
         p_fill_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_high && (fill_lines != '0)) |=> err_proto_o);
      end else begin : g_no_fill_check
         assign err_proto_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/adcrd_pins.sv
module adcrd_pins
   import adcrd_pkg::*;
(
   input  seq_t   st,
   input  phase_t ph,
   output logic   cs_n_o,
   output logic   rd_n_o,
   output logic   hben_o
);

   logic active;

   assign active = (st != S_IDLE) && (st != S_DONE);
   assign cs_n_o = !active;
   assign rd_n_o = (st != S_STRB);
   assign hben_o = active && ((ph == PH_HIGH) || (ph == PH_END));

endmodule

// File: rtl/adc_byte_reader.sv
module adc_byte_reader
   import adcrd_pkg::*;
#(
   parameter int unsigned STROBE_CYC  = 2,
   parameter int unsigned GAP_CYC     = 2,
   parameter int unsigned TIMEOUT_CYC = 1000,
   parameter bit          CHECK_FILL  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             mode_byte_i,
   input  logic             busy_i,
   input  logic [RES_W-1:0] data_i,
   output logic             cs_n_o,
   output logic             rd_n_o,
   output logic             hben_o,
   output logic             done_o,
   output logic [RES_W-1:0] result_o,
   output logic             err_proto_o,
   output logic             err_timeout_o
);

   initial begin
      assert (STROBE_CYC >= 1)  else $error("adc_byte_reader: STROBE_CYC must be >= 1");
      assert (GAP_CYC >= 1)     else $error("adc_byte_reader: GAP_CYC must be >= 1");
      assert (TIMEOUT_CYC >= 2) else $error("adc_byte_reader: TIMEOUT_CYC must be >= 2");
   end

   seq_t   st_q;
   phase_t ph_q;
   logic   byte_q;
   logic   tmo_q;

   logic strobe_run, gap_run, wait_run;
   logic strobe_hit, gap_hit, wait_expire;
   logic cap_low, cap_high, start;

   assign strobe_run = (st_q == S_STRB);
   assign gap_run    = (st_q == S_GAP);
   assign wait_run   = (st_q == S_ARM) || (st_q == S_WLO) || (st_q == S_WHI);

   adcrd_pace #(.LIMIT(STROBE_CYC)) u_strobe (
      .clk(clk), .rst_n(rst_n), .run(strobe_run), .hit(strobe_hit));

   adcrd_pace #(.LIMIT(GAP_CYC)) u_gap (
      .clk(clk), .rst_n(rst_n), .run(gap_run), .hit(gap_hit));

   adcrd_pace #(.LIMIT(TIMEOUT_CYC)) u_wait (
      .clk(clk), .rst_n(rst_n), .run(wait_run), .hit(wait_expire));

   assign start    = (st_q == S_IDLE) && req_i;
   assign cap_low  = strobe_hit && (ph_q == PH_LOW);
   assign cap_high = strobe_hit && (ph_q == PH_HIGH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         ph_q   <= PH_TRIG;
         byte_q <= 1'b0;
         tmo_q  <= 1'b0;
      end else begin
         unique case (st_q)
            S_IDLE: begin
               if (req_i) begin
                  st_q   <= S_ARM;
                  ph_q   <= PH_TRIG;
                  byte_q <= mode_byte_i;
                  tmo_q  <= 1'b0;
               end
            end
            S_ARM: begin
               if (busy_i) begin
                  st_q <= S_STRB;
               end else if (wait_expire) begin
                  tmo_q <= 1'b1;
                  st_q  <= S_DONE;
               end
            end
            S_STRB: begin
               if (strobe_hit) begin
                  st_q <= S_GAP;
                  if (ph_q == PH_LOW) begin
                     ph_q <= byte_q ? PH_HIGH : PH_END;
                  end else if (ph_q == PH_HIGH) begin
                     ph_q <= PH_END;
                  end
               end
            end
            S_GAP: begin
               if (gap_hit) begin
                  if (ph_q == PH_TRIG) begin
                     st_q <= S_WLO;
                  end else if (ph_q == PH_HIGH) begin
                     st_q <= S_STRB;
                  end else begin
                     st_q <= S_DONE;
                  end
               end
            end
            S_WLO: begin
               if (!busy_i) begin
                  st_q <= S_WHI;
               end else if (wait_expire) begin
                  tmo_q <= 1'b1;
                  st_q  <= S_DONE;
               end
            end
            S_WHI: begin
               if (busy_i) begin
                  st_q <= S_STRB;
                  ph_q <= PH_LOW;
               end else if (wait_expire) begin
                  tmo_q <= 1'b1;
                  st_q  <= S_DONE;
               end
            end
            S_DONE: begin
               st_q <= S_IDLE;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   adcrd_pins u_pins (
      .st(st_q), .ph(ph_q),
      .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .hben_o(hben_o));

   adcrd_assemble #(.CHECK_FILL(CHECK_FILL)) u_asm (
      .clk(clk), .rst_n(rst_n), .start(start), .word_mode(!byte_q),
      .cap_low(cap_low), .cap_high(cap_high), .data_i(data_i),
      .result_o(result_o), .err_proto_o(err_proto_o));

   assign done_o        = (st_q == S_DONE);
   assign err_timeout_o = tmo_q;

   // ---------------- assertion support: run lengths of the read line
   logic [15:0] lo_run, hi_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_run <= '0;
         hi_run <= '0;
      end else if (!rd_n_o) begin
         hi_run <= '0;
         if (lo_run != 16'hFFFF) lo_run <= lo_run + 1'b1;
      end else begin
         lo_run <= '0;
         if (hi_run != 16'hFFFF) hi_run <= hi_run + 1'b1;
      end
   end

   // R2: every strobe lasts exactly STROBE_CYC cycles
   p_strobe_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_n_o) |-> (lo_run == 16'(STROBE_CYC)));

   // R3: read strobe only under an asserted select
   p_rd_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n_o |-> !cs_n_o);

   // R4: byte-select frozen while the strobe is low
   p_hben_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n_o && $past(!rd_n_o)) |-> (hben_o == $past(hben_o)));

   // R5: idle gap before every data strobe
   p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rd_n_o) && (ph_q != PH_TRIG)) |-> (hi_run >= 16'(GAP_CYC)));

   // R6: data read only once the status line is back high
   p_read_after_conv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rd_n_o) && (ph_q == PH_LOW)) |-> $past(busy_i));

   // R11: done lasts a single cycle
   p_done_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R12: trigger only while the converter is idle
   p_trig_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rd_n_o) && (ph_q == PH_TRIG)) |-> $past(busy_i));

endmodule

// File: tb/adc_byte_reader_bench.sv
module adc_byte_reader_bench;

   localparam int CLK_PERIOD = 10;
   localparam int STROBE     = 3;
   localparam int GAP        = 2;
   localparam int TIMEOUT    = 40;
   localparam int CONV       = 12;
   localparam int NVEC       = 6;

   // {mode_byte, analog value}
   localparam logic [12:0] VEC [NVEC] = '{
      {1'b0, 12'hA5C}, {1'b1, 12'h3E7}, {1'b0, 12'hFFF},
      {1'b1, 12'h000}, {1'b1, 12'hC81}, {1'b0, 12'h001}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0;
   logic mode = 1'b0;
   logic busy_pin;
   logic [11:0] dbus;
   logic cs_n, rd_n, hben, done;
   logic [11:0] result;
   logic err_p, err_t;

   always #(CLK_PERIOD / 2) clk = ~clk;

   adc_byte_reader #(
      .STROBE_CYC(STROBE), .GAP_CYC(GAP), .TIMEOUT_CYC(TIMEOUT), .CHECK_FILL(1'b1)
   ) u_adc_byte_reader (
      .clk(clk), .rst_n(rst_n), .req_i(req), .mode_byte_i(mode),
      .busy_i(busy_pin), .data_i(dbus), .cs_n_o(cs_n), .rd_n_o(rd_n),
      .hben_o(hben), .done_o(done), .result_o(result),
      .err_proto_o(err_p), .err_timeout_o(err_t));

   // ---------------- converter model
   logic [11:0] analog = '0;
   logic [11:0] sample = '0;
   logic [11:0] held   = '0;
   logic [3:0]  bad_fill = '0;
   logic        stuck = 1'b0;
   logic        hold_low = 1'b0;
   logic        busy_m;
   logic        rd_q;
   int          conv_cnt;

   always @(posedge clk) begin
      rd_q <= rd_n;
      if (!rst_n) begin
         busy_m   <= 1'b1;
         conv_cnt <= 0;
         held     <= '0;
      end else if (conv_cnt != 0) begin
         conv_cnt <= conv_cnt - 1;
         if (conv_cnt == 1) begin
            busy_m <= 1'b1;
            held   <= sample;
         end
      end else if (!cs_n && !rd_n && rd_q && !hben && busy_pin && !stuck) begin
         busy_m   <= 1'b0;
         conv_cnt <= CONV;
         sample   <= analog;
      end
   end

   assign busy_pin = busy_m && !hold_low;
   assign dbus = (!cs_n && !rd_n) ?
                 (hben ? {held[11:8], bad_fill, held[11:8]} : held) : 12'h000;

   // ---------------- pin monitor
   int nstr, wmin, wmax, gmin, lo, hi, dcnt;
   logic [3:0] hbp;
   bit seen_lo, order_bad, prev_rd, prev_cs;

   always @(negedge clk) begin
      if (!rst_n) begin
         prev_rd = 1'b1; prev_cs = 1'b1; nstr = 0; dcnt = 0;
      end else begin
         if (prev_cs && !cs_n) begin
            nstr = 0; wmin = 999; wmax = 0; gmin = 999; hbp = '0;
            lo = 0; hi = 0; seen_lo = 0; order_bad = 0; dcnt = 0;
         end
         if (!rd_n) begin
            if (prev_rd) begin
               if (nstr > 0 && hi < gmin) gmin = hi;
               if (nstr == 1 && !(seen_lo && busy_pin)) order_bad = 1;
               if (nstr < 4) hbp[nstr] = hben;
               nstr++;
               lo = 0;
            end
            lo++;
         end else begin
            if (!prev_rd) begin
               if (lo < wmin) wmin = lo;
               if (lo > wmax) wmax = lo;
               hi = 0;
            end
            hi++;
            if (nstr == 1 && !busy_pin) seen_lo = 1;
         end
         if (done) dcnt++;
         prev_rd = rd_n;
         prev_cs = cs_n;
      end
   end

   // ---------------- bookkeeping
   int n_chk = 0;
   int n_bad = 0;
   int cyc;
   logic [11:0] got_res;
   logic got_p, got_t;

   task automatic chk(input string tag, input bit ok, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic run_xfer(input bit m, input logic [11:0] a, input bit extra);
      analog = a;
      mode = m;
      @(negedge clk) req = 1'b1;
      @(negedge clk) req = 1'b0;
      cyc = 1;
      while (!done && cyc < 2000) begin
         req = extra && (cyc == 8);
         @(negedge clk);
         cyc++;
      end
      req = 1'b0;
      got_res = result;
      got_p = err_p;
      got_t = err_t;
      chk("R11 done seen", done == 1'b1, done, 1);
      repeat (2) @(negedge clk);
   endtask

   task automatic check_shape(input bit m);
      chk("R8 strobe count", nstr == (m ? 3 : 2), nstr, m ? 3 : 2);
      chk("R4 byte-select pattern", hbp[2:0] == (m ? 3'b100 : 3'b000), hbp, m ? 4 : 0);
      chk("R2 strobe width", (wmin == STROBE) && (wmax == STROBE), wmax, STROBE);
      chk("R5 gap", gmin >= GAP, gmin, GAP);
      chk("R6 read after conversion", order_bad == 0, order_bad, 0);
      chk("R11 one done", dcnt == 1, dcnt, 1);
   endtask

   // watchdog
   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 cs_n", cs_n == 1'b1, cs_n, 1);
      chk("R1 rd_n", rd_n == 1'b1, rd_n, 1);
      chk("R1 hben", hben == 1'b0, hben, 0);
      chk("R1 done", done == 1'b0, done, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // vector table: R7 word and R8 byte results
      for (int i = 0; i < NVEC; i++) begin
         run_xfer(VEC[i][12], VEC[i][11:0], 1'b0);
         chk(VEC[i][12] ? "R8 byte result" : "R7 word result",
             got_res == VEC[i][11:0], got_res, VEC[i][11:0]);
         chk("R9 no fill error", got_p == 1'b0, got_p, 0);
         chk("R10 no timeout", got_t == 1'b0, got_t, 0);
         check_shape(VEC[i][12]);
         repeat (CONV + 4) @(negedge clk);
      end

      // R9 nonzero fill lines during the upper fetch
      bad_fill = 4'h5;
      run_xfer(1'b1, 12'h9B4, 1'b0);
      chk("R9 fill error flagged", got_p == 1'b1, got_p, 1);
      chk("R8 result despite fill", got_res == 12'h9B4, got_res, 12'h9B4);
      bad_fill = 4'h0;
      repeat (CONV + 4) @(negedge clk);

      // R11 extra request mid-transfer is ignored
      run_xfer(1'b0, 12'h456, 1'b1);
      chk("R7 result with extra req", got_res == 12'h456, got_res, 12'h456);
      repeat (10) @(negedge clk);
      chk("R11 no second transfer", (cs_n == 1'b1) && (dcnt == 1), dcnt, 1);
      repeat (CONV + 4) @(negedge clk);

      // R10 status never falls after trigger
      stuck = 1'b1;
      run_xfer(1'b0, 12'h111, 1'b0);
      chk("R10 timeout flag", got_t == 1'b1, got_t, 1);
      chk("R10 timeout latency", (cyc >= TIMEOUT) && (cyc <= TIMEOUT + 20), cyc, TIMEOUT);
      chk("R10 select released", cs_n == 1'b1, cs_n, 1);
      chk("R10 single trigger", nstr == 1, nstr, 1);
      stuck = 1'b0;
      repeat (4) @(negedge clk);

      // R12 converter busy before the request: no strobe, then timeout
      hold_low = 1'b1;
      run_xfer(1'b1, 12'h222, 1'b0);
      chk("R12 no strobe while busy", nstr == 0, nstr, 0);
      chk("R10 timeout while arming", got_t == 1'b1, got_t, 1);
      hold_low = 1'b0;
      repeat (4) @(negedge clk);

      // recovery after errors
      run_xfer(1'b1, 12'h5A6, 1'b0);
      chk("R8 recovery result", got_res == 12'h5A6, got_res, 12'h5A6);
      chk("R10 flag cleared", got_t == 1'b0, got_t, 0);
      check_shape(1'b1);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule